// File: doc/BRIEF.md
# Vector Mask State Query Unit

This execution unit reports whether the bits of one or two vector registers are all clear, all set, or a mix of both. After a start strobe it reads the active elements of the first source through an element read port, one element per cycle. When two sources are selected it then reads the second source the same way. While it reads, it keeps two sticky flags: one records that some bit was one, the other that some bit was zero. At the end it encodes them as a 32-bit scalar.

The encoding is chosen so that ordinary sign and zero branches can act on it: zero for all clear, minus one for all set, plus one for mixed. With two sources the classification covers the union of both registers, as though they were one longer register. Only the first `vl_i` elements of each source are considered. A done pulse marks the cycle in which the result becomes valid, and the result stays on the port until the next accepted start.

Top module: `mask_state_query`

## Requirements
- R1: During and directly after reset, `busy_o`, `done_o` and `rd_en_o` are 0 and `result_o` is 0x00000000.
- R2: When every inspected bit is 0, `result_o` is 0x00000000 in the done cycle.
- R3: When every inspected bit is 1, `result_o` is 0xFFFFFFFF in the done cycle.
- R4: When the inspected bits hold at least one 1 and at least one 0, `result_o` is 0x00000001 in the done cycle. This holds whether the mix lies inside one element or across elements.
- R5: Only the elements at indices 0 to vl-1 are read, and no other element affects the result. Here vl is `vl_i` captured at the accepted start, with values above MAXVL treated as MAXVL.
- R6: With `two_src_i`=1 at start, the result classifies the union of source A's and source B's active elements. It is 0 only if both are all zero, 0xFFFFFFFF only if both are all ones, and 0x00000001 otherwise.
- R7: With vl=0, no element is read and the result is 0x00000000, with `done_o` raised in the cycle right after the start edge.
- R8: Counting the rising edge that accepts start as edge 0, `done_o` is high for exactly one cycle, right after edge N. N = vl for one source and 2*vl for two sources.
- R9: A start is accepted only while `busy_o` is 0. A start while busy changes neither the result, nor the done timing, nor the number of reads, and produces no extra done pulse.
- R10: `busy_o` is 1 from the cycle after an accepted start through the done cycle. `result_o` changes only in the done cycle and holds until the next done.
- R11: `rd_en_o` is 1 in exactly N cycles per operation. Source A is read first (`rd_src_o`=0) at indices 0 upward, then source B (`rd_src_o`=1) from index 0. `rd_data_i` is taken in the same cycle as the index it answers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| two_src_i | input | 1 | 1 = classify sources A and B together, 0 = source A only |
| vl_i | input | VL_W | Active vector length in elements |
| rd_en_o | output | 1 | Element read request |
| rd_src_o | output | 1 | Source of the read: 0 = A, 1 = B |
| rd_idx_o | output | IDX_W | Element index of the read |
| rd_data_i | input | ELEM_W | Element data, combinational answer to the current index |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| result_o | output | 32 | Class code: 0x00000000, 0xFFFFFFFF or 0x00000001 |

## Verification
The bench builds the unit with ELEM_W=16, MAXVL=8 and LANE_W=6. The narrow element makes all-ones patterns easy to write, and the short register lets full-length and over-range vector lengths (vl_i up to 15 on a 4-bit port) be exercised in a few cycles. A lane width that does not divide the element width leaves the last reduction lane partial, so its padding is exercised by both all-ones and single-bit mixed elements.

// File: rtl/msq_pkg.sv
package msq_pkg;

    localparam int RES_W = 32;

    localparam logic [RES_W-1:0] RES_ZERO  = 32'h0000_0000;
    localparam logic [RES_W-1:0] RES_ONES  = 32'hFFFF_FFFF;
    localparam logic [RES_W-1:0] RES_MIXED = 32'h0000_0001;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN_A = 2'd1,
        ST_SCAN_B = 2'd2,
        ST_DONE   = 2'd3
    } msq_state_e;

    typedef struct packed {
        logic seen_one;
        logic seen_zero;
    } msq_flags_t;

    function automatic logic [RES_W-1:0] encode_class(input msq_flags_t f);
        if (f.seen_one && f.seen_zero) begin
            return RES_MIXED;
        end else if (f.seen_one) begin
            return RES_ONES;
        end
        return RES_ZERO;
    endfunction

endpackage

// File: rtl/msq_elem_class.sv
module msq_elem_class #(
    parameter int ELEM_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [ELEM_W-1:0] elem_i,
    output logic              has_one_o,
    output logic              has_zero_o
);
    localparam int LANES = (ELEM_W + LANE_W - 1) / LANE_W;

    logic [LANES-1:0] lane_any;
    logic [LANES-1:0] lane_all;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LO = g * LANE_W;
        localparam int HI = ((g + 1) * LANE_W > ELEM_W) ? ELEM_W - 1 : (g + 1) * LANE_W - 1;
        assign lane_any[g] = |elem_i[HI:LO];
        assign lane_all[g] = &elem_i[HI:LO];
    end

    assign has_one_o  = |lane_any;
    assign has_zero_o = ~(&lane_all);

endmodule

// File: rtl/msq_seq.sv
module msq_seq
    import msq_pkg::*;
#(
    parameter int MAXVL = 32,
    parameter int VL_W  = $clog2(MAXVL + 1),
    parameter int IDX_W = $clog2(MAXVL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             two_src_i,
    input  logic [VL_W-1:0]  vl_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             rd_en_o,
    output logic             rd_src_o,
    output logic [IDX_W-1:0] rd_idx_o,
    output logic             clear_o,
    output logic             capture_o,
    output logic [VL_W-1:0]  act_vl_o
);
    localparam logic [VL_W-1:0]  VL_CAP  = VL_W'(MAXVL);
    localparam logic [VL_W-1:0]  VL_ONE  = VL_W'(1);
    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

    typedef struct packed {
        msq_state_e       state;
        logic [IDX_W-1:0] idx;
        logic [VL_W-1:0]  vl;
        logic             two;
    } seq_t;

    seq_t seq_d, seq_q;
    logic last_elem;
    logic accept;
    logic [VL_W-1:0] vl_clamped;

    always_comb begin
        vl_clamped = (vl_i > VL_CAP) ? VL_CAP : vl_i;
        last_elem  = (VL_W'(seq_q.idx) == (seq_q.vl - VL_ONE));
        accept     = start_i && (seq_q.state == ST_IDLE);
        seq_d      = seq_q;
        clear_o    = 1'b0;
        capture_o  = 1'b0;

        unique case (seq_q.state)
            ST_IDLE: begin
                if (accept) begin
                    clear_o   = 1'b1;
                    seq_d.vl  = vl_clamped;
                    seq_d.two = two_src_i;
                    seq_d.idx = '0;
                    if (vl_clamped == '0) begin
                        seq_d.state = ST_DONE;
                        capture_o   = 1'b1;
                    end else begin
                        seq_d.state = ST_SCAN_A;
                    end
                end
            end
            ST_SCAN_A: begin
                if (last_elem) begin
                    seq_d.idx = '0;
                    if (seq_q.two) begin
                        seq_d.state = ST_SCAN_B;
                    end else begin
                        seq_d.state = ST_DONE;
                        capture_o   = 1'b1;
                    end
                end else begin
                    seq_d.idx = seq_q.idx + IDX_ONE;
                end
            end
            ST_SCAN_B: begin
                if (last_elem) begin
                    seq_d.idx   = '0;
                    seq_d.state = ST_DONE;
                    capture_o   = 1'b1;
                end else begin
                    seq_d.idx = seq_q.idx + IDX_ONE;
                end
            end
            ST_DONE: begin
                seq_d.state = ST_IDLE;
            end
            default: begin
                seq_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, idx: '0, vl: '0, two: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o   = (seq_q.state != ST_IDLE);
    assign done_o   = (seq_q.state == ST_DONE);
    assign rd_en_o  = (seq_q.state == ST_SCAN_A) || (seq_q.state == ST_SCAN_B);
    assign rd_src_o = (seq_q.state == ST_SCAN_B);
    assign rd_idx_o = seq_q.idx;
    assign act_vl_o = seq_q.vl;

endmodule

// File: rtl/msq_accum.sv
module msq_accum
    import msq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             sample_i,
    input  logic             capture_i,
    input  logic             elem_one_i,
    input  logic             elem_zero_i,
    output logic [RES_W-1:0] result_o
);
    typedef struct packed {
        msq_flags_t       flags;
        logic [RES_W-1:0] result;
    } acc_t;

    acc_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clear_i) begin
            acc_d.flags = '0;
        end else if (sample_i) begin
            acc_d.flags.seen_one  = acc_q.flags.seen_one  | elem_one_i;
            acc_d.flags.seen_zero = acc_q.flags.seen_zero | elem_zero_i;
        end
        if (capture_i) begin
            acc_d.result = encode_class(acc_d.flags);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '{flags: '0, result: RES_ZERO};
        end else begin
            acc_q <= acc_d;
        end
    end

    assign result_o = acc_q.result;

endmodule

// File: rtl/mask_state_query.sv
module mask_state_query
    import msq_pkg::*;
#(
    parameter int ELEM_W = 64,
    parameter int MAXVL  = 32,
    parameter int LANE_W = 8,
    localparam int VL_W  = $clog2(MAXVL + 1),
    localparam int IDX_W = $clog2(MAXVL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              two_src_i,
    input  logic [VL_W-1:0]   vl_i,
    output logic              rd_en_o,
    output logic              rd_src_o,
    output logic [IDX_W-1:0]  rd_idx_o,
    input  logic [ELEM_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [31:0]       result_o
);
    logic            elem_one;
    logic            elem_zero;
    logic            clear;
    logic            capture;
    logic [VL_W-1:0] act_vl;

    msq_seq #(
        .MAXVL (MAXVL),
        .VL_W  (VL_W),
        .IDX_W (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .two_src_i (two_src_i),
        .vl_i      (vl_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .rd_en_o   (rd_en_o),
        .rd_src_o  (rd_src_o),
        .rd_idx_o  (rd_idx_o),
        .clear_o   (clear),
        .capture_o (capture),
        .act_vl_o  (act_vl)
    );

    msq_elem_class #(
        .ELEM_W (ELEM_W),
        .LANE_W (LANE_W)
    ) u_class (
        .elem_i     (rd_data_i),
        .has_one_o  (elem_one),
        .has_zero_o (elem_zero)
    );

    msq_accum u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (clear),
        .sample_i    (rd_en_o),
        .capture_i   (capture),
        .elem_one_i  (elem_one),
        .elem_zero_i (elem_zero),
        .result_o    (result_o)
    );

endmodule

// File: rtl/mask_state_query_chk.sv
module mask_state_query_chk #(
    parameter int ELEM_W = 64,
    parameter int MAXVL  = 32,
    parameter int VL_W   = $clog2(MAXVL + 1),
    parameter int IDX_W  = $clog2(MAXVL)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [31:0]       result_o,
    input logic              rd_en_o,
    input logic              rd_src_o,
    input logic [IDX_W-1:0]  rd_idx_o,
    input logic [ELEM_W-1:0] rd_data_i,
    input logic [VL_W-1:0]   act_vl
);
    logic ref_one_q, ref_zero_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_one_q  <= 1'b0;
            ref_zero_q <= 1'b0;
        end else if (start_i && !busy_o) begin
            ref_one_q  <= 1'b0;
            ref_zero_q <= 1'b0;
        end else if (rd_en_o) begin
            ref_one_q  <= ref_one_q  | (rd_data_i != '0);
            ref_zero_q <= ref_zero_q | (rd_data_i != '1);
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> (!done_o && !busy_o && !rd_en_o));

    a_r2_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ref_one_q) |-> (result_o == 32'h0000_0000));

    a_r3_ones_code: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ref_one_q && !ref_zero_q) |-> (result_o == 32'hFFFF_FFFF));

    a_r4_mixed_code: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ref_one_q && ref_zero_q) |-> (result_o == 32'h0000_0001));

    a_r5_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (VL_W'(rd_idx_o) < act_vl));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_busy_holds_vl: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(act_vl));

    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    a_r11_b_after_a: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && rd_src_o && rd_idx_o == '0) |-> ($past(rd_en_o) && !$past(rd_src_o)));

endmodule

bind mask_state_query mask_state_query_chk #(
    .ELEM_W (ELEM_W),
    .MAXVL  (MAXVL),
    .VL_W   (VL_W),
    .IDX_W  (IDX_W)
) u_chk (.*);

// File: tb/mask_state_query_test.sv
module mask_state_query_test;
    localparam int ELEM_W = 16;
    localparam int MAXVL  = 8;
    localparam int LANE_W = 6;
    localparam int VL_W   = $clog2(MAXVL + 1);
    localparam int IDX_W  = $clog2(MAXVL);
    localparam logic [ELEM_W-1:0] ONES = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              two_src_i = 1'b0;
    logic [VL_W-1:0]   vl_i = '0;
    logic              rd_en_o, rd_src_o, busy_o, done_o;
    logic [IDX_W-1:0]  rd_idx_o;
    logic [ELEM_W-1:0] rd_data_i;
    logic [31:0]       result_o;

    logic [ELEM_W-1:0] mem_a [MAXVL];
    logic [ELEM_W-1:0] mem_b [MAXVL];

    always #2.5 clk = ~clk;

    assign rd_data_i = rd_src_o ? mem_b[rd_idx_o] : mem_a[rd_idx_o];

    mask_state_query #(.ELEM_W(ELEM_W), .MAXVL(MAXVL), .LANE_W(LANE_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .two_src_i(two_src_i),
        .vl_i(vl_i), .rd_en_o(rd_en_o), .rd_src_o(rd_src_o), .rd_idx_o(rd_idx_o),
        .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int reads = 0;
    int bad_idx = 0;
    int cur_vl = 0;
    bit finished = 0;

    logic [31:0] exp_res_q[$];
    int          exp_lat_q[$];
    int          exp_rd_q[$];
    int          start_q[$];
    string       tag_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input int vl, input bit two);
        bit one = 0, zero = 0;
        for (int i = 0; i < vl; i++) begin
            if (mem_a[i] != '0) one = 1;
            if (mem_a[i] != ONES) zero = 1;
            if (two) begin
                if (mem_b[i] != '0) one = 1;
                if (mem_b[i] != ONES) zero = 1;
            end
        end
        if (one && zero) return 32'h0000_0001;
        if (one) return 32'hFFFF_FFFF;
        return 32'h0000_0000;
    endfunction

    // Monitor: pops one expected item per done pulse
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rd_en_o) begin
                reads++;
                if (int'(rd_idx_o) >= cur_vl) bad_idx++;
            end
            if (done_o) begin
                if (exp_res_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected done", result_o, 32'h0);
                end else begin
                    automatic logic [31:0] er = exp_res_q.pop_front();
                    automatic int el = exp_lat_q.pop_front();
                    automatic int erd = exp_rd_q.pop_front();
                    automatic int st = start_q.pop_front();
                    automatic string tg = tag_q.pop_front();
                    chk(result_o === er, tg, "result", result_o, er);
                    chk((cyc - st) == el, "R8", "done latency", 32'(cyc - st), 32'(el));
                    chk(reads == erd, "R11", "read count", 32'(reads), 32'(erd));
                end
                reads = 0;
            end
        end
    end

    task automatic run_op(input int vl, input bit two, input string tag, input bit poke_busy);
        int vlc = (vl > MAXVL) ? MAXVL : vl;
        int n = two ? 2 * vlc : vlc;
        exp_res_q.push_back(model(vlc, two));
        exp_lat_q.push_back(n);
        exp_rd_q.push_back(n);
        tag_q.push_back(tag);
        @(negedge clk);
        cur_vl = vlc;
        start_i = 1'b1;
        two_src_i = two;
        vl_i = VL_W'(vl);
        start_q.push_back(cyc + 1);
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o === 1'b1, "R10", "busy after start", 32'(busy_o), 32'h1);
        if (poke_busy) begin
            @(negedge clk);
            start_i = 1'b1;
            two_src_i = ~two;
            vl_i = VL_W'(1);
            @(negedge clk);
            start_i = 1'b0;
        end
        while (exp_res_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic fill(input logic [ELEM_W-1:0] a, input logic [ELEM_W-1:0] b);
        for (int i = 0; i < MAXVL; i++) begin
            mem_a[i] = a;
            mem_b[i] = b;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        fill('0, '0);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy_o === 1'b0, "R1", "busy in reset", 32'(busy_o), 32'h0);
        chk(done_o === 1'b0, "R1", "done in reset", 32'(done_o), 32'h0);
        chk(result_o === 32'h0, "R1", "result in reset", result_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_en_o === 1'b0, "R1", "no read after reset", 32'(rd_en_o), 32'h0);

        // R2 all zero
        fill('0, '0);
        run_op(8, 0, "R2", 0);
        // R3 all ones
        fill(ONES, ONES);
        run_op(8, 0, "R3", 0);
        // R4 mixed inside one element
        fill(16'h00FF, '0);
        run_op(1, 0, "R4", 0);
        // R4 single bit clear in the partial top lane
        fill(ONES, ONES);
        mem_a[2] = 16'h7FFF;
        run_op(4, 0, "R4", 0);
        // R4 mixed across elements
        fill('0, '0);
        mem_a[2] = ONES;
        run_op(3, 0, "R4", 0);
        // R5 elements beyond vl ignored
        fill('0, '0);
        for (int i = 0; i < 3; i++) mem_a[i] = ONES;
        run_op(3, 0, "R5", 0);
        chk(result_o === 32'hFFFF_FFFF, "R5", "tail ignored", result_o, 32'hFFFF_FFFF);
        // R5 over-range vl clamps to MAXVL
        fill(ONES, ONES);
        run_op(15, 0, "R5", 0);
        // R6 two sources
        fill('0, '0);
        run_op(5, 1, "R6", 0);
        fill(ONES, ONES);
        run_op(5, 1, "R6", 0);
        fill('0, ONES);
        run_op(5, 1, "R6", 0);
        fill(ONES, ONES);
        mem_b[4] = 16'hFFFE;
        run_op(5, 1, "R6", 0);
        mem_b[4] = '0;
        mem_b[5] = 16'h1234;
        run_op(5, 1, "R6", 0);
        // R7 zero length, after a nonzero result
        fill(ONES, ONES);
        run_op(4, 0, "R3", 0);
        run_op(0, 0, "R7", 0);
        run_op(0, 1, "R7", 0);
        // R8 short two-source op
        fill(ONES, '0);
        run_op(1, 1, "R8", 0);
        // R9 start while busy is ignored
        fill(ONES, '0);
        run_op(5, 0, "R9", 1);
        // R10 result holds while idle
        repeat (4) @(negedge clk);
        chk(result_o === 32'hFFFF_FFFF, "R10", "result held", result_o, 32'hFFFF_FFFF);
        chk(busy_o === 1'b0, "R10", "idle after done", 32'(busy_o), 32'h0);
        // R11 reads never left the active range
        chk(bad_idx == 0, "R11", "reads outside vl", 32'(bad_idx), 32'h0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule